// File: doc/BRIEF.md
# Video Switch Control Register Target

This block is the serial control target of a three-input video switch. It watches an open-drain two-wire bus (clock and data, both sampled on the system clock through two-flop synchronizers) and answers as a bus target at a 7-bit address whose lowest bit comes from a strap input. It holds three 8-bit registers. Their fields drive the switch directly: input port choice, output enable, hot-plug source, style and levels, per-input termination enables, sideband channel mode, output swing, pull-up, squelch, pre-emphasis and equalization.

A write transfer first loads a register pointer. Every later byte writes the register under the pointer, and the pointer then advances, wrapping from register 2 back to register 0. A read transfer starts at the current pointer and advances in the same way. Register 1 mixes stored bits with live status. Three bits show the connect state of each input, and one bit shows an interrupt flag that another block keeps. When the master acknowledges a register 1 byte, the target emits a one-cycle strobe, so that the other block can clear its flag. The data line is modelled as a sampled input plus an active-high pull-low enable.

Top module: `vsw_ctl_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 1010100 with its LSB replaced by `addr_strap`. The eighth bit selects the direction: 0 means write, 1 means read. On any other address it never pulls SDA low during that transfer.
- R2: After reset, register 0 reads 0x20, register 1 reads 0xE0 ORed with its live bits, register 2 reads 0x12, the pointer is 0 and `sda_oe` is 0.
- R3: In a write transfer, bits 1:0 of the first data byte load the pointer, and the value 3 selects register 0. Each following byte writes the register under the pointer, and the pointer then steps 0→1→2→0.
- R4: A read transfer returns the register under the current pointer and steps the pointer after each byte is loaded. The pointer is kept between transfers.
- R5: Register 1 reads as {stored bits 7:5, conn_st[2], conn_st[1], conn_st[0], irq_flag, stored bit 0}. Here conn_st[0] is input A and conn_st[2] is input C. Written values on bits 4:1 are ignored.
- R6: `rd_clr` is a single-cycle pulse given when the master ACKs a byte read from register 1. It is not given on a NACK, and it is not given for registers 0 or 2.
- R7: A NACK from the master ends a read. SDA then stays released until the next start condition.
- R8: A repeated start, with no stop before it, begins a new transfer. The pointer written just before it is kept.
- R9: A stop condition returns the target to idle and releases SDA. A byte that was only partly received is discarded.
- R10: The outputs map as follows. port_sel=reg0[7:6] (00 A, 01 B, 10 C, 11 none), out_en=reg0[5], hp_src=reg0[4], hp_style=reg0[3], hp_lvl=reg0[2:0] (bit0 A). term_en=reg1[7:5] (bit2 A, bit0 C), ddc_active=reg1[0]. swing=reg2[7:6], pullup_en=reg2[5], squelch_en=reg2[4], preemph=reg2[3:2], eq_sel=reg2[1:0].
- R11: The target begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 1 | Address LSB strap |
| conn_st | input | 3 | Live connect status, bit0 input A |
| irq_flag | input | 1 | Live interrupt flag |
| port_sel | output | 2 | Selected input |
| out_en | output | 1 | Video output enable |
| hp_src | output | 1 | Hot-plug source select |
| hp_style | output | 1 | Hot-plug output style |
| hp_lvl | output | 3 | Per-input hot-plug level |
| term_en | output | 3 | Per-input termination enable |
| ddc_active | output | 1 | Sideband channel active buffer mode |
| swing | output | 2 | Output swing code |
| pullup_en | output | 1 | Output pull-up enable |
| squelch_en | output | 1 | Output squelch enable |
| preemph | output | 2 | Pre-emphasis code |
| eq_sel | output | 2 | Equalization code |
| rd_clr | output | 1 | Register 1 read-acknowledged strobe |

## Verification
The cases hardest to reach are those where the master ends a transfer at an unusual moment. One is a stop in the middle of a byte. Another is a NACK after a register 1 byte compared with an ACK of the same byte. The third is a repeated start that follows a pointer write. The bench drives the bus bit by bit through its own master tasks, so it can stop after any bit, choose ACK or NACK for each byte, and leave out the stop. Randomly chosen transfers that mix pointers, lengths and live status values cover the wrap of the pointer from 2 to 0 and the mixing of live bits into register 1.

// File: rtl/vsw_ctl_target.sv
module vsw_ctl_target #(
  parameter logic [5:0] DEV_HI = 6'b101010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_strap,
  input  logic [2:0] conn_st,
  input  logic       irq_flag,
  output logic [1:0] port_sel,
  output logic       out_en,
  output logic       hp_src,
  output logic       hp_style,
  output logic [2:0] hp_lvl,
  output logic [2:0] term_en,
  output logic       ddc_active,
  output logic [1:0] swing,
  output logic       pullup_en,
  output logic       squelch_en,
  output logic [1:0] preemph,
  output logic [1:0] eq_sel,
  output logic       rd_clr
);
  localparam logic [7:0] R0_RST = 8'h20;
  localparam logic [7:0] R1_RST = 8'hE0;
  localparam logic [7:0] R2_RST = 8'h12;
  localparam logic [7:0] R1_WMSK = 8'hE1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK} st_t;

  st_t        st;
  logic [2:0] scl_p, sda_p;
  logic [7:0] shreg, r0, r1, r2, cur_byte;
  logic [3:0] bitcnt;
  logic [1:0] ptr, rd_idx;
  logic       rw, first, mack;

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire addr_hit  = (shreg[7:1] == {DEV_HI, addr_strap});

  function automatic logic [1:0] step(input logic [1:0] p);
    return (p == 2'd2) ? 2'd0 : p + 2'd1;
  endfunction

  always_comb begin
    case (ptr)
      2'd0:    cur_byte = r0;
      2'd1:    cur_byte = r1 | {3'b000, conn_st[2], conn_st[1], conn_st[0], irq_flag, 1'b0};
      default: cur_byte = r2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; bitcnt <= '0; ptr <= '0; rd_idx <= '0;
      rw <= 1'b0; first <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; rd_clr <= 1'b0;
      r0 <= R0_RST; r1 <= R1_RST; r2 <= R2_RST;
    end else begin
      rd_clr <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_p[1]};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  rw <= shreg[0]; sda_oe <= 1'b1; st <= S_AACK;
                end else st <= S_IDLE;
              end else begin
                sda_oe <= 1'b1; st <= S_WACK;
                if (first) begin
                  first <= 1'b0;
                  ptr   <= (shreg[1:0] == 2'd3) ? 2'd0 : shreg[1:0];
                end else begin
                  case (ptr)
                    2'd0:    r0 <= shreg;
                    2'd1:    r1 <= shreg & R1_WMSK;
                    default: r2 <= shreg;
                  endcase
                  ptr <= step(ptr);
                end
              end
            end
          end
          S_AACK, S_RACK: begin
            if (scl_rise && st == S_RACK) begin
              mack <= ~sda_p[1];
              if (!sda_p[1] && rd_idx == 2'd1) rd_clr <= 1'b1;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if ((st == S_AACK && rw) || (st == S_RACK && mack)) begin
                shreg <= cur_byte; rd_idx <= ptr; ptr <= step(ptr);
                sda_oe <= ~cur_byte[7]; st <= S_RDAT;
              end else if (st == S_AACK) begin
                sda_oe <= 1'b0; first <= 1'b1; st <= S_WDAT;
              end else begin
                sda_oe <= 1'b0; st <= S_IDLE;
              end
            end
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; bitcnt <= '0; st <= S_WDAT;
          end
          S_RDAT: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_RACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0}; sda_oe <= ~shreg[6];
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign port_sel   = r0[7:6];
  assign out_en     = r0[5];
  assign hp_src     = r0[4];
  assign hp_style   = r0[3];
  assign hp_lvl     = r0[2:0];
  assign term_en    = r1[7:5];
  assign ddc_active = r1[0];
  assign swing      = r2[7:6];
  assign pullup_en  = r2[5];
  assign squelch_en = r2[4];
  assign preemph    = r2[3:2];
  assign eq_sel     = r2[1:0];

  // R6
  rd_clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_clr |=> !rd_clr);
  // R6
  rd_clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |-> (st == S_RACK) && (rd_idx == 2'd1) && mack);
  // R11
  sda_take_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_p[1]));
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe && st == S_IDLE);
  // R1
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && !start_det && !stop_det && scl_fall && bitcnt == 4'd8 && !addr_hit) |=> !sda_oe);
endmodule

// File: tb/vsw_ctl_target_tb.sv
module vsw_ctl_target_tb_top;
  localparam int Q = 8;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0, irq = 1'b0;
  logic [2:0] plug = 3'b000;
  logic sda_oe, rd_clr, out_en, hp_src, hp_style, ddc_active, pullup_en, squelch_en;
  logic [1:0] port_sel, swing, preemph, eq_sel;
  logic [2:0] hp_lvl, term_en;
  wire sda_bus = sda_m & ~sda_oe;

  vsw_ctl_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .conn_st(plug), .irq_flag(irq),
    .port_sel(port_sel), .out_en(out_en), .hp_src(hp_src), .hp_style(hp_style), .hp_lvl(hp_lvl),
    .term_en(term_en), .ddc_active(ddc_active), .swing(swing), .pullup_en(pullup_en),
    .squelch_en(squelch_en), .preemph(preemph), .eq_sel(eq_sel), .rd_clr(rd_clr));

  int total = 0, fails = 0, clr_cnt = 0, exp_clr = 0, r11_bad = 0;
  logic [7:0] m0 = 8'h20, m1 = 8'hE0, m2 = 8'h12;
  logic [1:0] mptr = 2'd0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic oe_d = 1'b0;
  bit done = 0;

  always @(posedge clk) if (rd_clr) clr_cnt++;
  always @(negedge clk) begin
    if (sda_oe && !oe_d && scl_m) r11_bad++;
    oe_d <= sda_oe;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [6:0] dev();
    return {6'b101010, strap};
  endfunction
  function automatic logic [1:0] nx(input logic [1:0] p);
    return (p == 2'd2) ? 2'd0 : p + 2'd1;
  endfunction
  function automatic logic [7:0] mview(input logic [1:0] i);
    case (i)
      2'd0: return m0;
      2'd1: return m1 | {3'b000, plug, irq, 1'b0};
      default: return m2;
    endcase
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic b_start();  sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic b_stop();   sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic send_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic recv_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq(); endtask
  task automatic tx_byte(input logic [7:0] d, output bit ack);
    logic r;
    for (int b = 7; b >= 0; b--) send_bit(d[b]);
    recv_bit(r);
    ack = !r;
  endtask
  task automatic rx_byte(output logic [7:0] d, input bit ack);
    logic r;
    for (int b = 7; b >= 0; b--) begin recv_bit(r); d[b] = r; end
    send_bit(!ack);
  endtask

  task automatic m_write(input logic [6:0] a, input int n, input bit with_stop, output bit ok);
    bit ack;
    b_start();
    tx_byte({a, 1'b0}, ack);
    ok = ack;
    if (ack) for (int i = 0; i < n; i++) begin tx_byte(wbuf[i], ack); ok = ok & ack; end
    if (with_stop) b_stop();
  endtask
  task automatic m_read(input logic [6:0] a, input int n, output bit ok);
    bit ack;
    b_start();
    tx_byte({a, 1'b1}, ack);
    ok = ack;
    if (ack) for (int i = 0; i < n; i++) rx_byte(rbuf[i], i != n - 1);
    b_stop();
  endtask

  function automatic void mdl_write(input int n);
    if (n < 1) return;
    mptr = (wbuf[0][1:0] == 2'd3) ? 2'd0 : wbuf[0][1:0];
    for (int i = 1; i < n; i++) begin
      case (mptr)
        2'd0: m0 = wbuf[i];
        2'd1: m1 = wbuf[i] & 8'hE1;
        default: m2 = wbuf[i];
      endcase
      mptr = nx(mptr);
    end
  endfunction

  task automatic read_chk(input int n, input string tag);
    bit ok;
    logic [7:0] e [4];
    for (int i = 0; i < n; i++) begin
      e[i] = mview(mptr);
      if (i < n - 1 && mptr == 2'd1) exp_clr++;
      mptr = nx(mptr);
    end
    m_read(dev(), n, ok);
    chk(ok, {tag, " read address ack"}, 32'(ok), 1);
    for (int i = 0; i < n; i++) chk(rbuf[i] == e[i], {tag, " read data"}, 32'(rbuf[i]), 32'(e[i]));
    chk(clr_cnt == exp_clr, "R6 rd_clr count", 32'(clr_cnt), 32'(exp_clr));
  endtask

  task automatic outs_chk(input string tag);
    logic [19:0] act, exp;
    act = {port_sel, out_en, hp_src, hp_style, hp_lvl, term_en, ddc_active,
           swing, pullup_en, squelch_en, preemph, eq_sel};
    exp = {m0, m1[7:5], m1[0], m2};
    chk(act == exp, {tag, " R10 decoded outputs"}, 32'(act), 32'(exp));
  endtask

  initial begin
    bit ok;
    logic r;
    void'($urandom(32'h1d2c3b4a));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R2 sda_oe after reset", 32'(sda_oe), 0);
    outs_chk("R2 reset");
    read_chk(3, "R2 R4 reset values");

    // R1 mismatch: strap 0, address LSB 1
    wbuf[0] = 8'h02; wbuf[1] = 8'hFF;
    m_write(7'b1010101, 2, 1, ok);
    chk(!ok, "R1 wrong address not acked", 32'(ok), 0);
    outs_chk("R1 after ignored write");
    strap = 1'b1;
    wbuf[0] = 8'h00; wbuf[1] = 8'h5A;
    m_write(7'b1010101, 2, 1, ok);
    chk(ok, "R1 strapped address acked", 32'(ok), 1);
    mdl_write(2);
    outs_chk("R1 strapped write");

    // R5 read-only bits ignored, live bits merged
    wbuf[0] = 8'h01; wbuf[1] = 8'hFF;
    m_write(dev(), 2, 1, ok); mdl_write(2);
    chk(ok && m1 == 8'hE1, "R5 write ack", 32'(ok), 1);
    plug = 3'b101; irq = 1'b1; mptr = 2'd1;
    wbuf[0] = 8'h01; m_write(dev(), 1, 1, ok); mdl_write(1);
    read_chk(2, "R5 R6 reg1 live bits acked");
    wbuf[0] = 8'h01; m_write(dev(), 1, 1, ok); mdl_write(1);
    read_chk(1, "R6 reg1 nacked no strobe");

    // R3 wrap and pointer value 3
    wbuf[0] = 8'h02; wbuf[1] = 8'hC3; wbuf[2] = 8'h44; wbuf[3] = 8'h1E;
    m_write(dev(), 4, 1, ok); mdl_write(4);
    chk(ok, "R3 wrap write ack", 32'(ok), 1);
    outs_chk("R3 wrap");
    wbuf[0] = 8'h07; wbuf[1] = 8'h9B;
    m_write(dev(), 2, 1, ok); mdl_write(2);
    outs_chk("R3 pointer 3 selects reg0");

    // R8 repeated start after pointer write
    wbuf[0] = 8'h02;
    m_write(dev(), 1, 0, ok); mdl_write(1);
    read_chk(3, "R8 repeated start read");

    // R7 NACK releases SDA
    read_chk(1, "R7 single read");
    b_start();
    begin bit ack; tx_byte({dev(), 1'b1}, ack); end
    mptr = nx(mptr);
    begin logic [7:0] d; rx_byte(d, 0); end
    for (int i = 0; i < 9; i++) begin
      recv_bit(r);
      chk(r == 1'b1, "R7 SDA released after NACK", 32'(r), 1);
    end
    b_stop();

    // R9 stop in mid-byte
    b_start();
    begin bit ack; tx_byte({dev(), 1'b0}, ack); tx_byte(8'h00, ack); end
    mptr = 2'd0;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    b_stop();
    chk(sda_oe == 1'b0, "R9 released after stop", 32'(sda_oe), 0);
    outs_chk("R9 partial byte discarded");
    read_chk(1, "R9 register kept");

    // randomized traffic
    for (int it = 0; it < 30; it++) begin
      int op, n;
      plug = 3'($urandom); irq = 1'($urandom);
      op = $urandom_range(0, 2);
      if (op == 0) begin
        n = $urandom_range(1, 4);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
        m_write(dev(), n, 1, ok); mdl_write(n);
        chk(ok, "R3 random write ack", 32'(ok), 1);
      end else if (op == 1) begin
        read_chk($urandom_range(1, 3), "R4 random read");
      end else begin
        wbuf[0] = 8'($urandom);
        m_write(dev(), 1, 0, ok); mdl_write(1);
        read_chk($urandom_range(1, 4), "R8 random pointer then read");
      end
      outs_chk("R10 random");
    end
    chk(r11_bad == 0, "R11 SDA taken only with SCL low", 32'(r11_bad), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule